// File: doc/BRIEF.md
# Table Look-Up Data Counter

This block holds a 12-bit pointer into program memory that software uses to walk constant tables in program memory four bits at a time. The pointer shows up in the data-RAM address space as three neighbouring 4-bit registers, least significant first, starting at RAM address 0x7C. Ordinary nibble stores load the pointer and ordinary nibble loads read it back.

Two look-up requests use the pointer. Both present it as the address of a synchronous program-ROM read port. The low look-up hands back bits 3:0 of the addressed byte. The high look-up hands back bits 7:4 and then moves the pointer to the next byte. A table is therefore read as a low/high pair per byte. The ROM contents and the instruction decoder sit outside the block.

Top module: `tblptr_top`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0x000 and `lk_valid` is low.
- R2: A RAM write to address 0x7C+i (i = 0, 1, 2) loads pointer bits 4i+3:4i with `ram_wdata`. Writing 0, 8, 3 to 0x7C, 0x7D, 0x7E gives 0x380.
- R3: For `ram_addr` in 0x7C to 0x7E, `ram_hit` is high and `ram_rdata` shows that pointer nibble in the same cycle. For any other address, `ram_hit` is low and `ram_rdata` is 0.
- R4: RAM writes to addresses outside 0x7C to 0x7E have no effect on the pointer.
- R5: In any cycle with a look-up request, `rom_rd_en` is high and `rom_addr` equals the pointer. In a cycle with no request, `rom_rd_en` is low.
- R6: A low look-up gives `lk_valid` high in the next cycle, with `lk_data` = `rom_data[3:0]`. The pointer does not change.
- R7: A high look-up gives `lk_valid` high in the next cycle, with `lk_data` = `rom_data[7:4]`. The pointer increments by one on the edge that captures the request.
- R8: Incrementing from 0xFFF gives 0x000.
- R9: When a RAM write to a pointer nibble and a high look-up fall on the same edge, the written nibble takes the write data. The other nibbles take their incremented values.
- R10: When both look-up requests are raised together, the low look-up is served and the pointer is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ram_addr | input | 7 | Data-RAM nibble address |
| ram_wr_en | input | 1 | Data-RAM write strobe |
| ram_wdata | input | 4 | Data-RAM write nibble |
| ram_rdata | output | 4 | Pointer nibble selected by `ram_addr`, or 0 |
| ram_hit | output | 1 | `ram_addr` falls in the pointer window |
| lk_lo_req | input | 1 | Low-nibble look-up request |
| lk_hi_req | input | 1 | High-nibble look-up request with post-increment |
| rom_addr | output | 12 | Program-ROM read address |
| rom_rd_en | output | 1 | Program-ROM read enable |
| rom_data | input | 8 | Program-ROM byte, one cycle after `rom_rd_en` |
| lk_data | output | 4 | Selected nibble of the fetched byte |
| lk_valid | output | 1 | `lk_data` is valid this cycle |

## Verification
The pointer update from a nibble store and the post-increment from a high look-up can land on the same clock edge. The bench forces this in a directed case. It loads 0x0FF and then stores 0xA into the middle nibble together with a high look-up. It expects 0x1A0: the carry reaches the untouched top nibble, and the stored nibble overrides its incremented value. A random phase then mixes stores, including stores into the window, with both kinds of request. A behavioural reference model checks the ROM address, the look-up nibble and the readback on every clock.

// File: rtl/tblptr_pkg.sv
// Package: shared types for the table look-up pointer block.
// Assumes a nibble-oriented data path; the look-up kind is carried
// from the request cycle to the data cycle as an enum.
package tblptr_pkg;

    // Kind of look-up captured at the request edge
    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_LOW  = 2'd1,
        LK_HIGH = 2'd2
    } lk_kind_t;

endpackage

// File: rtl/tblptr_regmap.sv
// Module: tblptr_regmap
// Decodes the data-RAM address against the window of pointer nibbles.
// Produces one write-select line per nibble and a combinational
// readback. Assumes BASE_ADDR + NUM_NIB fits in the RAM address space.
module tblptr_regmap #(
    parameter int RAM_AW    = 7,
    parameter int NIB_W     = 4,
    parameter int NUM_NIB   = 3,
    parameter int BASE_ADDR = 'h7C,
    localparam int PTR_W    = NIB_W * NUM_NIB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RAM_AW-1:0]  ram_addr,
    input  logic               ram_wr_en,
    input  logic [PTR_W-1:0]   ptr,
    output logic [NUM_NIB-1:0] nib_wr_sel,
    output logic               ram_hit,
    output logic [NIB_W-1:0]   ram_rdata
);

    localparam logic [RAM_AW-1:0] BASE_L = RAM_AW'(BASE_ADDR);
    localparam logic [RAM_AW-1:0] SPAN_L = RAM_AW'(NUM_NIB);

    logic [RAM_AW-1:0] offset;

    // Offset of the access inside the pointer window
    assign offset  = ram_addr - BASE_L;
    assign ram_hit = (ram_addr >= BASE_L) && (offset < SPAN_L);

    // One write-select per nibble
    for (genvar k = 0; k < NUM_NIB; k++) begin : g_sel
        assign nib_wr_sel[k] = ram_wr_en && ram_hit && (offset == RAM_AW'(k));
    end

    // Readback mux: the addressed nibble, or zero outside the window
    always_comb begin
        ram_rdata = '0;
        for (int k = 0; k < NUM_NIB; k++) begin
            if (ram_hit && (offset == RAM_AW'(k))) begin
                ram_rdata = ptr[k*NIB_W +: NIB_W];
            end
        end
    end

    // R2: at most one nibble is written per cycle
    p_one_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nib_wr_sel));

    // R4: a write outside the window selects no nibble
    p_no_stray_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr_en && !ram_hit) |-> (nib_wr_sel == '0));

endmodule

// File: rtl/tblptr_counter.sv
// Module: tblptr_counter
// Holds the pointer as NUM_NIB separate nibble registers. Each nibble
// loads from the RAM write path when selected, else takes the
// incremented value when step is high, else holds. A write therefore
// overrides the increment only for the nibble it addresses.
module tblptr_counter #(
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 3,
    localparam int PTR_W  = NIB_W * NUM_NIB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [NUM_NIB-1:0] nib_wr_sel,
    input  logic [NIB_W-1:0]   wdata,
    output logic [PTR_W-1:0]   ptr
);

    logic [NIB_W-1:0] nib_q [NUM_NIB];
    logic [PTR_W-1:0] ptr_inc;

    // Next sequential address, wrapping at the top
    assign ptr_inc = ptr + PTR_W'(1);

    for (genvar k = 0; k < NUM_NIB; k++) begin : g_nib
        // Nibble register: write beats increment, increment beats hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_q[k] <= '0;
            end else if (nib_wr_sel[k]) begin
                nib_q[k] <= wdata;
            end else if (step) begin
                nib_q[k] <= ptr_inc[k*NIB_W +: NIB_W];
            end
        end

        assign ptr[k*NIB_W +: NIB_W] = nib_q[k];

        // R9: a written nibble holds the written value next cycle
        p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            nib_wr_sel[k] |=> (nib_q[k] == $past(wdata)));
    end

    // R7: a step without a write advances by one
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (nib_wr_sel == '0)) |=> (ptr == PTR_W'($past(ptr) + PTR_W'(1))));

    // R8: the top address rolls over to zero
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (&ptr) && (nib_wr_sel == '0)) |=> (ptr == '0));

    // R6: no step and no write keeps the pointer
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && (nib_wr_sel == '0)) |=> $stable(ptr));

endmodule

// File: rtl/tblptr_fetch.sv
// Module: tblptr_fetch
// Turns look-up requests into a ROM read and a pointer step. It then
// picks the requested half of the byte the ROM returns one cycle
// later. Assumes the ROM registers its output on the request edge.
// Low wins when both requests are raised together.
module tblptr_fetch
    import tblptr_pkg::*;
#(
    parameter int NIB_W  = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_req,
    input  logic              hi_req,
    input  logic [BYTE_W-1:0] rom_data,
    output logic              rd_en,
    output logic              step,
    output logic              lk_valid,
    output logic [NIB_W-1:0]  lk_data
);

    lk_kind_t kind_d, kind_q;

    // Request arbitration: low look-up has priority
    always_comb begin
        if (lo_req)      kind_d = LK_LOW;
        else if (hi_req) kind_d = LK_HIGH;
        else             kind_d = LK_NONE;
    end

    assign rd_en = lo_req || hi_req;
    assign step  = (kind_d == LK_HIGH);

    // Remember which half is wanted when the ROM data arrives
    always_ff @(posedge clk) begin
        if (!rst_n) kind_q <= LK_NONE;
        else        kind_q <= kind_d;
    end

    // Output selection on the data cycle
    always_comb begin
        lk_valid = (kind_q != LK_NONE);
        unique case (kind_q)
            LK_LOW:  lk_data = rom_data[NIB_W-1:0];
            LK_HIGH: lk_data = rom_data[BYTE_W-1:NIB_W];
            default: lk_data = '0;
        endcase
    end

    // R6/R7: any request gives a valid result in the next cycle
    p_valid_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_req || hi_req) |=> lk_valid);

    // R5: no request gives no result
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_req || hi_req) |=> !lk_valid);

    // R10: a low request never steps the pointer
    p_low_no_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lo_req |-> !step);

endmodule

// File: rtl/tblptr_top.sv
// Module: tblptr_top
// Table look-up pointer. A 12-bit program-memory pointer that is
// RAM-mapped as three nibbles and drives a synchronous ROM read port,
// with a post-incrementing high-nibble look-up. Assumes a ROM with
// exactly one cycle of read latency.
module tblptr_top #(
    parameter int RAM_AW    = 7,
    parameter int NIB_W     = 4,
    parameter int NUM_NIB   = 3,
    parameter int BASE_ADDR = 'h7C,
    localparam int PTR_W    = NIB_W * NUM_NIB,
    localparam int BYTE_W   = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAM_AW-1:0] ram_addr,
    input  logic              ram_wr_en,
    input  logic [NIB_W-1:0]  ram_wdata,
    output logic [NIB_W-1:0]  ram_rdata,
    output logic              ram_hit,
    input  logic              lk_lo_req,
    input  logic              lk_hi_req,
    output logic [PTR_W-1:0]  rom_addr,
    output logic              rom_rd_en,
    input  logic [BYTE_W-1:0] rom_data,
    output logic [NIB_W-1:0]  lk_data,
    output logic              lk_valid
);

    logic [PTR_W-1:0]   ptr;
    logic [NUM_NIB-1:0] nib_wr_sel;
    logic               step;

    // RAM window decode and readback
    tblptr_regmap #(
        .RAM_AW(RAM_AW), .NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .BASE_ADDR(BASE_ADDR)
    ) i_regmap (
        .clk(clk), .rst_n(rst_n),
        .ram_addr(ram_addr), .ram_wr_en(ram_wr_en), .ptr(ptr),
        .nib_wr_sel(nib_wr_sel), .ram_hit(ram_hit), .ram_rdata(ram_rdata)
    );

    // Pointer storage with write/increment merge
    tblptr_counter #(
        .NIB_W(NIB_W), .NUM_NIB(NUM_NIB)
    ) i_counter (
        .clk(clk), .rst_n(rst_n),
        .step(step), .nib_wr_sel(nib_wr_sel), .wdata(ram_wdata), .ptr(ptr)
    );

    // Request handling and nibble selection
    tblptr_fetch #(
        .NIB_W(NIB_W)
    ) i_fetch (
        .clk(clk), .rst_n(rst_n),
        .lo_req(lk_lo_req), .hi_req(lk_hi_req), .rom_data(rom_data),
        .rd_en(rom_rd_en), .step(step), .lk_valid(lk_valid), .lk_data(lk_data)
    );

    assign rom_addr = ptr;

    // R5: a ROM read is always followed by a look-up result
    p_rd_then_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_en |=> lk_valid);

    // R3: readback is zero whenever the window is missed
    p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_hit |-> (ram_rdata == '0));

endmodule

// File: tb/test_tblptr_top.sv
module test_tblptr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ram_addr = 7'h00;
    logic        ram_wr_en = 1'b0;
    logic [3:0]  ram_wdata = 4'h0;
    logic [3:0]  ram_rdata;
    logic        ram_hit;
    logic        lk_lo_req = 1'b0;
    logic        lk_hi_req = 1'b0;
    logic [11:0] rom_addr;
    logic        rom_rd_en;
    logic [7:0]  rom_data = 8'h00;
    logic [3:0]  lk_data;
    logic        lk_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_live = 1'b0;

    // Reference model state
    int m_ptr = 0;
    bit m_pend = 1'b0;
    bit m_hi = 1'b0;
    int m_byte = 0;

    always #10 clk = ~clk;

    tblptr_top i_tblptr_top (
        .clk(clk), .rst_n(rst_n),
        .ram_addr(ram_addr), .ram_wr_en(ram_wr_en), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .ram_hit(ram_hit),
        .lk_lo_req(lk_lo_req), .lk_hi_req(lk_hi_req),
        .rom_addr(rom_addr), .rom_rd_en(rom_rd_en), .rom_data(rom_data),
        .lk_data(lk_data), .lk_valid(lk_valid)
    );

    function automatic logic [7:0] rom_fn(input int a);
        return 8'(((a * 29) ^ (a >> 3)) + 7);
    endfunction

    // Synchronous ROM with one cycle of latency
    always @(posedge clk) begin
        if (rom_rd_en) rom_data <= rom_fn(int'(rom_addr));
    end

    // Behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_pend = 0; m_hi = 0; model_live = 1'b1;
        end else begin
            int np;
            m_pend = lk_lo_req || lk_hi_req;
            m_hi   = lk_hi_req && !lk_lo_req;
            m_byte = int'(rom_fn(m_ptr));
            np = m_hi ? ((m_ptr + 1) % 4096) : m_ptr;
            if (ram_wr_en && ram_addr >= 7'h7C && ram_addr <= 7'h7E) begin
                int sh;
                sh = 4 * (int'(ram_addr) - 'h7C);
                np = (np & ~(15 << sh)) | (int'(ram_wdata) << sh);
            end
            m_ptr = np;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, mid-cycle
    always @(negedge clk) begin
        if (model_live && rst_n) begin
            bit inwin;
            int exp_rd;
            inwin = (ram_addr >= 7'h7C && ram_addr <= 7'h7E);
            exp_rd = inwin ? ((m_ptr >> (4 * (int'(ram_addr) - 'h7C))) & 15) : 0;
            chk(rom_rd_en == (lk_lo_req || lk_hi_req), "R5 rd_en", int'(rom_rd_en),
                int'(lk_lo_req || lk_hi_req));
            if (rom_rd_en) chk(int'(rom_addr) == m_ptr, "R5 rom_addr", int'(rom_addr), m_ptr);
            chk(lk_valid == m_pend, "R6 valid", int'(lk_valid), int'(m_pend));
            if (m_pend) begin
                int en;
                en = m_hi ? ((m_byte >> 4) & 15) : (m_byte & 15);
                chk(int'(lk_data) == en, m_hi ? "R7 hi data" : "R6 lo data", int'(lk_data), en);
            end
            chk(ram_hit == inwin, "R3 hit", int'(ram_hit), int'(inwin));
            chk(int'(ram_rdata) == exp_rd, "R3 rdata", int'(ram_rdata), exp_rd);
        end
    end

    // One bus cycle: drive just after the rising edge
    task automatic cyc(input bit lo, input bit hi, input bit we, input logic [6:0] a,
                       input logic [3:0] d);
        @(posedge clk);
        #2;
        lk_lo_req = lo; lk_hi_req = hi; ram_wr_en = we; ram_addr = a; ram_wdata = d;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 7'h00, 4'h0);
    endtask

    // Read the pointer through the RAM window within the current cycle
    task automatic read_ptr(output int v);
        v = 0;
        for (int k = 0; k < 3; k++) begin
            ram_addr = 7'(7'h7C + k);
            #1;
            v = v | (int'(ram_rdata) << (4 * k));
        end
    endtask

    task automatic load_ptr(input int v);
        for (int k = 0; k < 3; k++) cyc(0, 0, 1, 7'(7'h7C + k), 4'((v >> (4 * k)) & 15));
        idle();
    endtask

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1: reset state
        read_ptr(v);
        chk(v == 0, "R1 ptr", v, 0);
        chk(lk_valid == 1'b0, "R1 valid", int'(lk_valid), 0);

        // R2: nibble order, least significant first
        cyc(0, 0, 1, 7'h7C, 4'h0);
        cyc(0, 0, 1, 7'h7D, 4'h8);
        cyc(0, 0, 1, 7'h7E, 4'h3);
        idle();
        read_ptr(v);
        chk(v == 'h380, "R2 load", v, 'h380);

        // R4: writes just outside the window are ignored
        cyc(0, 0, 1, 7'h7B, 4'hF);
        cyc(0, 0, 1, 7'h7F, 4'hF);
        idle();
        read_ptr(v);
        chk(v == 'h380, "R4 stray", v, 'h380);
        ram_addr = 7'h7F; #1;
        chk(ram_hit == 1'b0, "R3 miss", int'(ram_hit), 0);

        // R6/R7: table walk as low/high pairs, back to back
        cyc(1, 0, 0, 7'h00, 4'h0);
        cyc(0, 1, 0, 7'h00, 4'h0);
        cyc(1, 0, 0, 7'h00, 4'h0);
        cyc(0, 1, 0, 7'h00, 4'h0);
        cyc(0, 1, 0, 7'h00, 4'h0);
        idle();
        idle();
        read_ptr(v);
        chk(v == 'h383, "R7 advance", v, 'h383);

        // R8: wrap from the top address
        load_ptr('hFFF);
        cyc(0, 1, 0, 7'h00, 4'h0);
        idle();
        read_ptr(v);
        chk(v == 0, "R8 wrap", v, 0);

        // R9: same-edge write into the middle nibble and increment
        load_ptr('h0FF);
        cyc(0, 1, 1, 7'h7D, 4'hA);
        idle();
        read_ptr(v);
        chk(v == 'h1A0, "R9 merge", v, 'h1A0);

        // R10: both requests give the low nibble, no increment
        load_ptr('h2C5);
        cyc(1, 1, 0, 7'h00, 4'h0);
        idle();
        chk(int'(lk_data) == (int'(rom_fn('h2C5)) & 15), "R10 low data",
            int'(lk_data), int'(rom_fn('h2C5)) & 15);
        read_ptr(v);
        chk(v == 'h2C5, "R10 no step", v, 'h2C5);

        // Mixed traffic, compared every clock by the model
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 15));
            cyc(r[0], r[1], r[2] & r[3], 7'(7'h7A + $urandom_range(0, 6)),
                4'($urandom_range(0, 15)));
        end
        idle();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule